// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block performs one complete page-program transaction on an 8-bit asynchronous NAND bus, one bus cycle per clock. On a start pulse it latches a page number, a page-size selector and the device's address-cycle count. It then writes the program-setup command, the column bytes, the row bytes, the page data and the spare bytes, and the program-confirm command. Each bus byte is marked as a command (CLE high), an address (ALE high) or data (both low).

Data and spare bytes arrive on a valid/ready byte stream. When the caller flags a byte as the last one, every remaining byte position up to the end of the spare area is written as 0xFF. After the confirm command the block waits a bounded time for the ready/busy line. If the device becomes ready, the block issues a read-status command, reads one status byte and reports pass or fail. If the wait runs out, it reports a timeout.

Top module: `nand_prog_seq`

## Requirements
- R1: A start seen while idle with `pg_sel` 0, 1 or 2 makes the first bus cycle a command write of 0x80 in the cycle after start. With `pg_sel` = 3 the block writes nothing and completes with result 3.
- R2: After the setup command come all-zero column address writes (ALE high): one for `pg_sel` 0 (512-byte page) and two for `pg_sel` 1 or 2.
- R3: Row address bytes follow, least significant first. Let E be `addr_cyc` minus 1 when `pg_sel` is 0, and `addr_cyc` otherwise. Bits 7:0 and 15:8 are always sent. Bits 23:16 are sent when E is at least 1. Bits 31:24 are sent when E equals 2.
- R4: Data writes (CLE and ALE low) carry the stream bytes in order. Their total count is 528 for `pg_sel` 0, 2112 for 1 and 4224 for 2 (page plus 16, 64 or 128 spare bytes).
- R5: Once a byte flagged with `s_last` has been accepted, `s_ready` stays low and every remaining data position is written as 0xFF.
- R6: `s_ready` is low during command and address cycles, so no stream byte is taken while they are in progress.
- R7: The command write 0x10 follows the final data byte directly.
- R8: If `nand_rb` is high in any of the TICK_DIV*POLL_LIMIT cycles after the confirm write, the block proceeds to read status. If it is never high in that window, the block completes with result 2 and performs no further bus cycles.
- R9: When the device is ready, the block writes command 0x70 and then makes exactly one read strobe. The result is 1 if bit 0 of the status byte read is set, and 0 otherwise.
- R10: `busy` is high from the cycle after an accepted start through the cycle in which `done` pulses for one cycle. A start while busy is ignored.
- R11: CLE and ALE are never high together, and write and read strobes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| pg_sel | input | 2 | Page size: 0=512, 1=2048, 2=4096, 3=invalid |
| addr_cyc | input | 3 | Total address cycles of the device |
| page_num | input | 32 | Row (page) address |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final supplied byte |
| s_ready | output | 1 | Block accepts a stream byte this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 fail, 2 timeout, 3 bad page size |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe for this cycle's byte |
| nand_re | output | 1 | Read strobe |
| nand_dout | output | 8 | Byte driven to the device |
| nand_din | input | 8 | Byte read from the device |
| nand_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The critical coincidence is the device becoming ready in the same cycle that the poll window expires. The design must then let ready win. The bench provokes this by raising `nand_rb` exactly in the last window cycle, and expects the status command and a pass. It then raises `nand_rb` one cycle later and expects a timeout with no status command. A second overlap is a stream byte flagged last arriving together with the final page position. It is judged by checking that the confirm command follows immediately and no padding byte is written.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_COL, S_ROW, S_DATA, S_CONF, S_WAIT, S_SCMD, S_SRD, S_DONE
  } st_t;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_FAIL    = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;
  localparam logic [1:0] RES_BADSIZE = 2'd3;

  localparam logic [7:0] OP_SETUP   = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam int CNT_W = 13;

  // page plus spare byte count per selector
  function automatic logic [CNT_W-1:0] stream_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(512 + 16);
      2'd1:    return CNT_W'(2048 + 64);
      default: return CNT_W'(4096 + 128);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] col_len(input logic [1:0] sel);
    return (sel == 2'd0) ? CNT_W'(1) : CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] row_len(input logic [1:0] sel, input logic [2:0] cyc);
    int extra;
    extra = int'(cyc) - ((sel == 2'd0) ? 1 : 0);
    return CNT_W'(2 + ((extra >= 1) ? 1 : 0) + ((extra == 2) ? 1 : 0));
  endfunction
endpackage

// File: rtl/nps_timer.sv
module nps_timer #(
  parameter int TICK_DIV   = 4,
  parameter int POLL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int DIV_W  = $clog2(TICK_DIV + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [POLL_W-1:0] tick_cnt;
  logic              tick;

  assign tick   = run && (div_cnt == DIV_W'(TICK_DIV - 1));
  assign expire = tick && (tick_cnt == POLL_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (!run) begin
      div_cnt  <= '0;
      tick_cnt <= '0;
    end else if (tick) begin
      div_cnt  <= '0;
      tick_cnt <= tick_cnt + POLL_W'(1);
    end else begin
      div_cnt  <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/nps_bus_drv.sv
module nps_bus_drv
  import nps_pkg::*;
(
  input  st_t                state,
  input  logic [CNT_W-1:0]   idx,
  input  logic [31:0]        page,
  input  logic               padding,
  input  logic               s_valid,
  input  logic [7:0]         s_data,
  output logic               s_ready,
  output logic               we,
  output logic               re,
  output logic               cle,
  output logic               ale,
  output logic [7:0]         dout
);
  always_comb begin
    we      = 1'b0;
    re      = 1'b0;
    cle     = 1'b0;
    ale     = 1'b0;
    dout    = 8'h00;
    s_ready = 1'b0;
    case (state)
      S_SETUP: begin we = 1'b1; cle = 1'b1; dout = OP_SETUP; end
      S_COL:   begin we = 1'b1; ale = 1'b1; end
      S_ROW:   begin we = 1'b1; ale = 1'b1; dout = 8'(page >> (idx[1:0] * 8)); end
      S_DATA: begin
        s_ready = !padding;
        we      = padding || s_valid;
        dout    = padding ? 8'hFF : s_data;
      end
      S_CONF:  begin we = 1'b1; cle = 1'b1; dout = OP_CONFIRM; end
      S_SCMD:  begin we = 1'b1; cle = 1'b1; dout = OP_STATUS; end
      S_SRD:   re = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int POLL_LIMIT = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  pg_sel,
  input  logic [2:0]  addr_cyc,
  input  logic [31:0] page_num,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we,
  output logic        nand_re,
  output logic [7:0]  nand_dout,
  input  logic [7:0]  nand_din,
  input  logic        nand_rb
);
  st_t              state;
  logic [CNT_W-1:0] idx;
  logic [31:0]      page_q;
  logic [1:0]       sel_q;
  logic [2:0]       cyc_q;
  logic             padding;
  logic [1:0]       res_q;

  // named events for the checker
  logic evt_wr, evt_rd, evt_expire, evt_take, evt_last_taken;
  logic [CNT_W-1:0] n_col, n_row, n_data;

  assign n_col  = col_len(sel_q);
  assign n_row  = row_len(sel_q, cyc_q);
  assign n_data = stream_len(sel_q);

  nps_bus_drv u_drv (
    .state(state), .idx(idx), .page(page_q), .padding(padding),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .we(evt_wr), .re(evt_rd), .cle(nand_cle), .ale(nand_ale), .dout(nand_dout)
  );

  nps_timer #(.TICK_DIV(TICK_DIV), .POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAIT), .expire(evt_expire)
  );

  assign evt_take       = s_ready && s_valid;
  assign evt_last_taken = evt_take && s_last;
  assign nand_we        = evt_wr;
  assign nand_re        = evt_rd;
  assign busy           = (state != S_IDLE);
  assign done           = (state == S_DONE);
  assign result         = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      page_q  <= '0;
      sel_q   <= '0;
      cyc_q   <= '0;
      padding <= 1'b0;
      res_q   <= RES_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          page_q  <= page_num;
          sel_q   <= pg_sel;
          cyc_q   <= addr_cyc;
          idx     <= '0;
          padding <= 1'b0;
          if (pg_sel == 2'd3) begin
            res_q <= RES_BADSIZE;
            state <= S_DONE;
          end else begin
            state <= S_SETUP;
          end
        end
        S_SETUP: state <= S_COL;
        S_COL: begin
          if (idx == n_col - CNT_W'(1)) begin
            idx   <= '0;
            state <= S_ROW;
          end else idx <= idx + CNT_W'(1);
        end
        S_ROW: begin
          if (idx == n_row - CNT_W'(1)) begin
            idx   <= '0;
            state <= S_DATA;
          end else idx <= idx + CNT_W'(1);
        end
        S_DATA: begin
          if (evt_last_taken) padding <= 1'b1;
          if (evt_wr) begin
            if (idx == n_data - CNT_W'(1)) state <= S_CONF;
            idx <= idx + CNT_W'(1);
          end
        end
        S_CONF: state <= S_WAIT;
        S_WAIT: begin
          if (nand_rb) state <= S_SCMD;
          else if (evt_expire) begin
            res_q <= RES_TIMEOUT;
            state <= S_DONE;
          end
        end
        S_SCMD: state <= S_SRD;
        S_SRD: begin
          res_q <= nand_din[0] ? RES_FAIL : RES_OK;
          state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nps_chk.sv
module nps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       s_ready,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we,
  input logic       nand_re,
  input logic [7:0] nand_dout,
  input logic [7:0] nand_din,
  input logic       nand_rb,
  input logic       evt_expire,
  input logic       evt_last_taken
);
  // R11
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_we && nand_re));
  // R6
  no_take_in_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> !s_ready);
  // R1
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !done) |-> (nand_we && nand_cle && nand_dout == 8'h80));
  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last_taken |=> !s_ready);
  // R8
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_expire && !nand_rb) |=> (done && result == 2'd2));
  // R9
  status_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re |=> (done && result == ($past(nand_din[0]) ? 2'd1 : 2'd0)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind nand_prog_seq nps_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .s_ready(s_ready), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we(nand_we), .nand_re(nand_re), .nand_dout(nand_dout),
  .nand_din(nand_din), .nand_rb(nand_rb), .evt_expire(evt_expire),
  .evt_last_taken(evt_last_taken)
);

// File: tb/nand_prog_seq_test.sv
module nand_prog_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int PLIM = 100;
  localparam int WIN  = TDIV * PLIM;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] pg_sel = '0;
  logic [2:0] addr_cyc = '0;
  logic [31:0] page_num = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0, nand_din = '0;
  logic nand_rb = 1'b1;
  logic s_ready, busy, done, nand_cle, nand_ale, nand_we, nand_re;
  logic [1:0] result;
  logic [7:0] nand_dout;

  int checks = 0, failures = 0;
  logic [9:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_prog_seq #(.TICK_DIV(TDIV), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pg_sel(pg_sel), .addr_cyc(addr_cyc),
    .page_num(page_num), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .busy(busy), .done(done), .result(result),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re),
    .nand_dout(nand_dout), .nand_din(nand_din), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 8));
  endfunction

  // sel, cyc, page, bytes supplied, ready delay, status byte, poke a start mid-op
  task automatic run_op(input int sel, input int cyc, input logic [31:0] pg,
                        input int nsup, input int rdel, input logic [7:0] stat,
                        input bit poke);
    int psz, total, extra, nrow, sidx, wpos, rd_seen, ncyc, exp_res;
    bit in_wait, take, hdr_take, late_take, seen_done;
    expq.delete();
    exp_res = 0;
    if (sel == 3) exp_res = 3;
    else begin
      psz   = (sel == 0) ? 528 : (sel == 1) ? 2112 : 4224;
      total = psz;
      expq.push_back({2'b10, 8'h80});                       // R1
      repeat ((sel == 0) ? 1 : 2) expq.push_back({2'b01, 8'h00}); // R2
      extra = cyc - ((sel == 0) ? 1 : 0);
      nrow  = 2 + ((extra >= 1) ? 1 : 0) + ((extra == 2) ? 1 : 0);
      for (int r = 0; r < nrow; r++) expq.push_back({2'b01, 8'(pg >> (8 * r))}); // R3
      for (int i = 0; i < total; i++)                        // R4 R5
        expq.push_back({2'b00, (i < nsup) ? dbyte(i) : 8'hFF});
      expq.push_back({2'b10, 8'h10});                       // R7
      if (rdel < WIN) begin
        expq.push_back({2'b10, 8'h70});                     // R9
        exp_res = stat[0] ? 1 : 0;
      end else exp_res = 2;                                 // R8
    end
    nand_din = stat;
    sidx = 0; wpos = 0; rd_seen = 0; ncyc = 0;
    in_wait = 0; hdr_take = 0; late_take = 0; seen_done = 0;
    @(posedge clk); #1;
    start = 1; pg_sel = 2'(sel); addr_cyc = 3'(cyc); page_num = pg;
    s_valid = 0; s_last = 0; nand_rb = 1;
    @(posedge clk); #1;
    start = 0; pg_sel = 2'd3;
    while (!seen_done) begin
      @(negedge clk);
      ncyc++;
      chk(busy == 1'b1, "R10 busy during op", busy, 1);
      take = s_valid && s_ready;
      if (s_ready && (nand_cle || nand_ale)) hdr_take = 1;
      if (s_ready && sidx >= nsup) late_take = 1;
      if (nand_we) begin
        if (expq.size() == 0) chk(0, "R4 unexpected write", nand_dout, 0);
        else begin
          logic [9:0] e;
          e = expq.pop_front();
          chk({nand_cle, nand_ale, nand_dout} == e, "R1-R9 bus write", {nand_cle, nand_ale, nand_dout}, e);
        end
        if (nand_cle && nand_dout == 8'h10) begin in_wait = 1; wpos = 0; end
        if (nand_cle && nand_dout == 8'h70) in_wait = 0;
      end
      if (nand_re) rd_seen++;
      if (done) begin
        seen_done = 1;
        chk(result == 2'(exp_res), "R8 R9 result", result, exp_res);
        chk(expq.size() == 0, "R4 R7 writes all issued", expq.size(), 0);
        chk(rd_seen == ((exp_res <= 1 && sel != 3) ? 1 : 0), "R9 read strobes", rd_seen, 1);
        chk(!hdr_take, "R6 no take in header", hdr_take, 0);
        chk(!late_take, "R5 ready low after last", late_take, 0);
      end
      @(posedge clk); #1;
      if (take) sidx++;
      s_valid = (sidx < nsup) && ((ncyc % 5) != 3);
      s_data  = dbyte(sidx);
      s_last  = (sidx == nsup - 1);
      nand_rb = in_wait ? (wpos >= rdel) : 1'b1;
      if (in_wait) wpos++;
      start = poke && (ncyc == 3);
    end
    start = 0;
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !nand_we && !nand_re && !s_ready, "R10 reset state", busy, 0);
    rst_n = 1;
    // R1 R2 R3 R10: small page, 4 row bytes, full supply, pass, start poked while busy
    run_op(0, 3, 32'hA1B2C3D4, 528, 5, 8'h00, 1);
    // R3 R4 R9: 2 KiB page, 3 row bytes, data only then padded spare, status fail
    run_op(1, 4, 32'h00123456, 2048, 0, 8'h01, 0);
    // R5 R8: 4 KiB page, short supply, ready in last window cycle (ready wins)
    run_op(2, 3, 32'h0000BEEF, 100, WIN - 1, 8'hE0, 0);
    // R8: ready one cycle too late -> timeout
    run_op(0, 2, 32'h00000777, 528, WIN, 8'h00, 0);
    // R3: 512 page, 2 row bytes, last byte exactly on final position
    run_op(0, 1, 32'h0000CAFE, 528, 1, 8'h02, 0);
    // R1: invalid page size
    run_op(3, 3, 32'h1, 0, 0, 8'h00, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule